// File: doc/BRIEF.md
# H-Bridge Drive Command Generator

This block turns a signed speed command into the two logic-level command lines of a DC-motor H-bridge. The line called `drv_a` drives the first half-bridge and `drv_b` the second. A level pair of (1,0) turns the motor clockwise and (0,1) turns it counterclockwise. A pair of (0,0) brakes through both low-side switches and (1,1) brakes through both high-side switches.

Three drive schemes can be selected. The static scheme gives fixed direction levels with no modulation. The sign/magnitude scheme holds one line high and pulse-width modulates the other, and the sign of the command picks which line is modulated. The locked anti-phase scheme drives one PWM waveform on `drv_a` and its complement on `drv_b`, so that the duty cycle alone carries both direction and amplitude. A brake request overrides every scheme. A single up-counting time base sets the PWM period. The mode, speed and period are sampled only at period boundaries, so no pulse is ever truncated.

Top module: `hbdrv_pwm_gen`

## Requirements
- R1: With the active mode code 0 (static), the outputs are constant: (drv_a,drv_b) = (1,0) for a positive speed, (0,1) for a negative speed and (0,0) for zero. The pair (1,1) never occurs unless a brake is requested.
- R2: With mode code 1 (sign/magnitude) and speed s >= 0, drv_a stays high. drv_b is high for P-|s| of every P cycles, where P = period_cfg+1, so a larger command leaves drv_b low for longer.
- R3: With mode code 1 and s < 0, the roles are swapped: drv_b stays high and drv_a is high for P-|s| of every P cycles.
- R4: In mode 1, |s| >= P holds the modulated line low without pause. s = 0 gives both lines constantly high (brake through the high side). At least one line is high in every cycle.
- R5: With mode code 2 (locked anti-phase), drv_a is high for floor(P/2)+s of every P cycles, and drv_b is the complement of drv_a in every cycle.
- R6: In mode 2, a value floor(P/2)+s of 0 or below makes drv_a constantly low, and a value of P or above makes drv_a constantly high.
- R7: Mode code 3 behaves exactly like mode code 0.
- R8: A new mode, speed or period takes effect only after the counter wraps. The PWM high time already under way completes with its old length.
- R9: While brake_req is high, one clock later both outputs equal brake_hi, in every mode and regardless of the speed value.
- R10: During reset both outputs are low, and the counter never exceeds the period value in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Drive scheme: 0 static, 1 sign/magnitude, 2 locked anti-phase, 3 same as 0 |
| speed_cmd | input | SPD_W | Signed speed command, in counter ticks |
| brake_req | input | 1 | Brake request, overrides the speed command |
| brake_hi | input | 1 | Brake level: 1 selects the high-side brake, 0 the low-side brake |
| period_cfg | input | CNT_W | PWM period minus one, in clock cycles |
| drv_a | output | 1 | Command line for the first half-bridge |
| drv_b | output | 1 | Command line for the second half-bridge |

## Verification
The bench sweeps every mode code over three period lengths, two of them even and one odd. For each pair it steps the speed from below -P to above +P, so every sweep crosses zero, the exact saturation points and values beyond them. Counting the high cycles of each line over one full period shows which line is modulated, how its duty depends on |s| or on floor(P/2)+s, and whether the saturated levels are held. A separate run changes the speed in the middle of a high pulse, which shows whether the update waits for the wrap. Brake runs in the anti-phase mode show the one-cycle override and both brake levels.

// File: rtl/hbdrv_pkg.sv
package hbdrv_pkg;

    typedef enum logic [1:0] {
        DRV_STATIC    = 2'd0,
        DRV_SIGNMAG   = 2'd1,
        DRV_ANTIPHASE = 2'd2,
        DRV_SPARE     = 2'd3
    } drv_mode_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } leg_pair_t;

    function automatic leg_pair_t brake_pair(input logic hi);
        leg_pair_t p;
        p.lead  = hi;
        p.trail = hi;
        return p;
    endfunction

    function automatic leg_pair_t dir_pair(input logic pos, input logic neg);
        leg_pair_t p;
        p.lead  = pos;
        p.trail = neg;
        return p;
    endfunction

    function automatic drv_mode_e decode_mode(input logic [1:0] code);
        drv_mode_e m;
        case (code)
            2'd1:    m = DRV_SIGNMAG;
            2'd2:    m = DRV_ANTIPHASE;
            2'd3:    m = DRV_SPARE;
            default: m = DRV_STATIC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hbdrv_timebase.sv
module hbdrv_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = (cnt_q == limit);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/hbdrv_shadow.sv
module hbdrv_shadow #(
    parameter int CNT_W = 8,
    parameter int SPD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  hbdrv_pkg::drv_mode_e     mode_in,
    input  logic signed [SPD_W-1:0]  speed_in,
    input  logic [CNT_W-1:0]         per_in,
    output hbdrv_pkg::drv_mode_e     mode_act,
    output logic signed [SPD_W-1:0]  speed_act,
    output logic [CNT_W-1:0]         per_act
);
    import hbdrv_pkg::*;

    drv_mode_e               mode_q;
    logic signed [SPD_W-1:0] speed_q;
    logic [CNT_W-1:0]        per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= DRV_STATIC;
            speed_q <= '0;
            per_q   <= '0;
        end else if (load) begin
            mode_q  <= mode_in;
            speed_q <= speed_in;
            per_q   <= per_in;
        end
    end

    assign mode_act  = mode_q;
    assign speed_act = speed_q;
    assign per_act   = per_q;
endmodule

// File: rtl/hbdrv_level_map.sv
module hbdrv_level_map #(
    parameter int CNT_W = 8,
    parameter int SPD_W = 8
) (
    input  logic [CNT_W-1:0]         cnt,
    input  hbdrv_pkg::drv_mode_e     mode,
    input  logic signed [SPD_W-1:0]  speed,
    input  logic [CNT_W-1:0]         per,
    output hbdrv_pkg::leg_pair_t     legs
);
    import hbdrv_pkg::*;

    localparam int IW = ((CNT_W > SPD_W) ? CNT_W : SPD_W) + 3;

    logic [IW-1:0]        span;
    logic [IW-1:0]        cnt_x;
    logic signed [IW-1:0] spd_s;
    logic [IW-1:0]        mag;
    logic [IW-1:0]        cmp_sm;
    logic signed [IW-1:0] half_s;
    logic signed [IW-1:0] ap_raw;
    logic [IW-1:0]        cmp_ap;
    logic                 pwm_sm;
    logic                 pwm_ap;
    logic                 neg;
    logic                 pos;

    assign span   = IW'(per) + IW'(1);
    assign cnt_x  = IW'(cnt);
    assign spd_s  = IW'(speed);
    assign neg    = spd_s < 0;
    assign pos    = spd_s > 0;
    assign mag    = neg ? $unsigned(-spd_s) : $unsigned(spd_s);

    // sign/magnitude: high time shrinks as |speed| grows
    assign cmp_sm = (mag >= span) ? '0 : (span - mag);

    // locked anti-phase: centred on half period, saturated to [0, span]
    assign half_s = $signed(span >> 1);
    assign ap_raw = half_s + spd_s;

    always_comb begin
        if (ap_raw < 0) begin
            cmp_ap = '0;
        end else if (ap_raw > $signed(span)) begin
            cmp_ap = span;
        end else begin
            cmp_ap = $unsigned(ap_raw);
        end
    end

    assign pwm_sm = cnt_x < cmp_sm;
    assign pwm_ap = cnt_x < cmp_ap;

    always_comb begin
        case (mode)
            DRV_SIGNMAG: begin
                if (neg) legs = dir_pair(pwm_sm, 1'b1);
                else     legs = dir_pair(1'b1, pwm_sm);
            end
            DRV_ANTIPHASE: legs = dir_pair(pwm_ap, ~pwm_ap);
            default:       legs = dir_pair(pos, neg);
        endcase
    end
endmodule

// File: rtl/hbdrv_pwm_gen.sv
module hbdrv_pwm_gen #(
    parameter int CNT_W = 8,
    parameter int SPD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              mode_sel,
    input  logic signed [SPD_W-1:0] speed_cmd,
    input  logic                    brake_req,
    input  logic                    brake_hi,
    input  logic [CNT_W-1:0]        period_cfg,
    output logic                    drv_a,
    output logic                    drv_b
);
    import hbdrv_pkg::*;

    logic [CNT_W-1:0]        cnt;
    logic                    wrap;
    drv_mode_e               act_mode;
    logic signed [SPD_W-1:0] act_speed;
    logic [CNT_W-1:0]        act_per;
    leg_pair_t               legs_run;
    leg_pair_t               legs_nxt;
    leg_pair_t               legs_q;

    hbdrv_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk   (clk),
        .rst   (rst),
        .limit (act_per),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    hbdrv_shadow #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .load      (wrap),
        .mode_in   (decode_mode(mode_sel)),
        .speed_in  (speed_cmd),
        .per_in    (period_cfg),
        .mode_act  (act_mode),
        .speed_act (act_speed),
        .per_act   (act_per)
    );

    hbdrv_level_map #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_map (
        .cnt   (cnt),
        .mode  (act_mode),
        .speed (act_speed),
        .per   (act_per),
        .legs  (legs_run)
    );

    assign legs_nxt = brake_req ? brake_pair(brake_hi) : legs_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            legs_q <= brake_pair(1'b0);
        end else begin
            legs_q <= legs_nxt;
        end
    end

    assign drv_a = legs_q.lead;
    assign drv_b = legs_q.trail;
endmodule

// File: rtl/hbdrv_pwm_checks.sv
module hbdrv_pwm_checks #(
    parameter int CNT_W = 8,
    parameter int SPD_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    brake_req,
    input logic                    brake_hi,
    input logic                    drv_a,
    input logic                    drv_b,
    input logic [CNT_W-1:0]        cnt,
    input hbdrv_pkg::drv_mode_e    act_mode,
    input logic signed [SPD_W-1:0] act_speed,
    input logic [CNT_W-1:0]        act_per
);
    import hbdrv_pkg::*;

    assert_brake_override_R9: assert property (@(posedge clk) disable iff (rst)
        brake_req |=> (drv_a == $past(brake_hi) && drv_b == $past(brake_hi)));

    assert_antiphase_complement_R5: assert property (@(posedge clk) disable iff (rst)
        (!brake_req && act_mode == DRV_ANTIPHASE) |=> (drv_a != drv_b));

    assert_static_no_high_pair_R1: assert property (@(posedge clk) disable iff (rst)
        (!brake_req && (act_mode == DRV_STATIC || act_mode == DRV_SPARE)) |=> !(drv_a && drv_b));

    assert_signmag_one_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!brake_req && act_mode == DRV_SIGNMAG) |=> (drv_a || drv_b));

    assert_update_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt != act_per) |=> ($stable(act_mode) && $stable(act_speed) && $stable(act_per)));

    assert_count_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= act_per);
endmodule

bind hbdrv_pwm_gen hbdrv_pwm_checks #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .brake_req (brake_req),
    .brake_hi  (brake_hi),
    .drv_a     (drv_a),
    .drv_b     (drv_b),
    .cnt       (cnt),
    .act_mode  (act_mode),
    .act_speed (act_speed),
    .act_per   (act_per)
);

// File: tb/hbdrv_pwm_gen_bench.sv
`timescale 1ns/1ps
module hbdrv_pwm_gen_bench;
    localparam int CNT_W = 8;
    localparam int SPD_W = 8;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [1:0]              mode_sel = 2'd0;
    logic signed [SPD_W-1:0] speed_cmd = '0;
    logic                    brake_req = 1'b0;
    logic                    brake_hi = 1'b0;
    logic [CNT_W-1:0]        period_cfg = '0;
    logic                    drv_a;
    logic                    drv_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    hbdrv_pwm_gen #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_hbdrv_pwm_gen (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .speed_cmd  (speed_cmd),
        .brake_req  (brake_req),
        .brake_hi   (brake_hi),
        .period_cfg (period_cfg),
        .drv_a      (drv_a),
        .drv_b      (drv_b)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (mode %0d P %0d s %0d)",
                     req, act, exp, mode_sel, int'(period_cfg) + 1, speed_cmd);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count high samples of each line over n cycles
    task automatic measure(input int n, output int ha, output int hb);
        ha = 0;
        hb = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(drv_a);
            hb += int'(drv_b);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic expect_counts(input int m, input int p, input int s,
                                 output int ea, output int eb, output string req);
        int mag;
        int hm;
        int t;
        mag = (s < 0) ? -s : s;
        hm  = (mag >= p) ? 0 : p - mag;
        case (m)
            1: begin
                if (s >= 0) begin ea = p;  eb = hm; req = (mag >= p || s == 0) ? "R4" : "R2"; end
                else        begin ea = hm; eb = p;  req = (mag >= p) ? "R4" : "R3"; end
            end
            2: begin
                t  = clampi(p / 2 + s, 0, p);
                ea = t;
                eb = p - t;
                req = (p / 2 + s <= 0 || p / 2 + s >= p) ? "R6" : "R5";
            end
            default: begin
                ea = (s > 0) ? p : 0;
                eb = (s < 0) ? p : 0;
                req = (m == 3) ? "R7" : "R1";
            end
        endcase
    endtask

    initial begin : wdog
        #(1_500_000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        int ha;
        int hb;
        int ea;
        int eb;
        int run;
        string req;
        int plist[3] = '{4, 7, 16};

        // reset state, R10
        cycles(3);
        check("R10 reset drv_a", int'(drv_a), 0);
        check("R10 reset drv_b", int'(drv_b), 0);
        rst = 1'b0;

        // sweep of modes, periods and speeds: R1..R7
        for (int m = 0; m < 4; m++) begin
            foreach (plist[k]) begin
                for (int s = -(plist[k] + 2); s <= plist[k] + 2; s++) begin
                    mode_sel   = 2'(m);
                    period_cfg = CNT_W'(plist[k] - 1);
                    speed_cmd  = SPD_W'(s);
                    cycles(2 * 17 + 4);
                    measure(plist[k], ha, hb);
                    expect_counts(m, plist[k], s, ea, eb, req);
                    check({req, " drv_a high count"}, ha, ea);
                    check({req, " drv_b high count"}, hb, eb);
                end
            end
        end

        // R8: speed change inside a high pulse, anti-phase, P = 16
        mode_sel   = 2'd2;
        period_cfg = CNT_W'(15);
        speed_cmd  = SPD_W'(-4);
        cycles(40);
        run = 0;
        while (drv_a) @(negedge clk);
        while (!drv_a) @(negedge clk);
        speed_cmd = SPD_W'(6);
        while (drv_a) begin
            run++;
            @(negedge clk);
        end
        check("R8 old pulse width kept", run, 4);
        while (!drv_a) @(negedge clk);
        run = 0;
        while (drv_a) begin
            run++;
            @(negedge clk);
        end
        check("R8 new pulse width after wrap", run, 14);

        // R9: brake override, high side then low side
        brake_hi  = 1'b1;
        brake_req = 1'b1;
        cycles(1);
        check("R9 brake high drv_a after one cycle", int'(drv_a), 1);
        check("R9 brake high drv_b after one cycle", int'(drv_b), 1);
        measure(16, ha, hb);
        check("R9 brake high drv_a held", ha, 16);
        check("R9 brake high drv_b held", hb, 16);
        brake_hi = 1'b0;
        speed_cmd = SPD_W'(100);
        cycles(1);
        check("R9 brake low drv_a after one cycle", int'(drv_a), 0);
        check("R9 brake low drv_b after one cycle", int'(drv_b), 0);
        mode_sel = 2'd1;
        cycles(40);
        measure(16, ha, hb);
        check("R9 brake low drv_a held in mode 1", ha, 0);
        check("R9 brake low drv_b held in mode 1", hb, 0);
        brake_req = 1'b0;
        speed_cmd = SPD_W'(3);
        cycles(40);
        measure(16, ha, hb);
        check("R2 resume after brake drv_a", ha, 16);
        check("R2 resume after brake drv_b", hb, 13);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule